// File: doc/BRIEF.md
# Decoded Integer ALU with Barrel Shifter

This block is the execute stage arithmetic unit of a simple 32-bit integer core, with the instruction decode for that stage folded in. The pipeline hands it the raw primary opcode, the function code, the shift-amount field, the two source register values and the 16-bit immediate. The block returns a 32-bit result, a flag that tells whether that result is zero, and a flag for an encoding it does not implement. The block holds no state: all outputs follow the inputs within the same cycle.

Register-format operations select their function from the function code. Immediate-format operations select it from the opcode. The opcode also chooses how the immediate is widened: sign extension for arithmetic and compare, zero extension for the bitwise operations, and placement in the upper half for the load-upper operation. Shifts take their distance from the shift-amount field and act on the second register operand. When an immediate is in use, it replaces the second register operand, so that operand is not read.

Top module: `rdec_alu`

## Requirements
- R1: With op_code 0x00, fn_code 0x20 gives src_a + src_b and fn_code 0x22 gives src_a - src_b, both modulo 2^32.
- R2: With op_code 0x00, fn_code 0x24 gives the bitwise AND, 0x25 the bitwise OR and 0x27 the inverted OR of src_a and src_b.
- R3: With op_code 0x00 and fn_code 0x2A, res is 1 when src_a is less than src_b as signed two's-complement values, and 0 otherwise.
- R4: With op_code 0x00, fn_code 0x00 shifts src_b left, 0x02 shifts it right with zero fill, and 0x03 shifts it right while filling with bit 31 of src_b. The distance is sh_amt (0 to 31), and src_a has no effect.
- R5: op_code 0x08 gives src_a plus imm16 sign-extended to 32 bits, and src_b has no effect.
- R6: op_code 0x0A gives 1 when src_a is less than sign-extended imm16 (signed compare), and 0 otherwise.
- R7: op_code 0x0C gives src_a AND imm16, and op_code 0x0D gives src_a OR imm16. In both cases imm16 is zero-extended.
- R8: op_code 0x0F gives imm16 in bits 31:16 and zero in bits 15:0, and src_a has no effect.
- R9: res_zero is 1 exactly when all 32 bits of res are 0.
- R10: Any other op_code, or op_code 0x00 with any other fn_code, drives res to 0 and bad_op to 1. bad_op is 0 for every encoding listed in R1 to R8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 6 | Primary opcode of the instruction |
| fn_code | input | 6 | Function code used when op_code is 0x00 |
| sh_amt | input | 5 | Shift distance for the shift operations |
| src_a | input | 32 | First source register value |
| src_b | input | 32 | Second source register value (value to shift for shifts) |
| imm16 | input | 16 | Immediate field of the instruction |
| res | output | 32 | Operation result |
| res_zero | output | 1 | High when res is all zeros |
| bad_op | output | 1 | High for an encoding the block does not implement |

## Verification
The bench targets the sign boundaries. It compares 0x80000000 against 0x7FFFFFFF, which a design comparing unsigned would order the wrong way. It uses an immediate of 0xFFFF on the add and compare paths, where zero extension turns minus one into 65535. It uses an immediate of 0x8000 on the bitwise paths, where sign extension would leak ones into the upper half. Shifts run at distances 0, 4 and 31 on a negative value, so swapping the fill bit between the two right shifts shows up in the top bits, and so does a left shift that reuses the right-shift core with the operand misordered. Unused operands carry nonzero values, and several unimplemented encodings are applied, to catch a design that reads the wrong operand or leaves stale results on an unknown encoding.

// File: rtl/rdec_pkg.sv
package rdec_pkg;
  localparam int XLEN  = 32;
  localparam int IMM_W = 16;

  localparam logic [5:0] OPC_REG  = 6'h00;
  localparam logic [5:0] OPC_ADDI = 6'h08;
  localparam logic [5:0] OPC_SLTI = 6'h0A;
  localparam logic [5:0] OPC_ANDI = 6'h0C;
  localparam logic [5:0] OPC_ORI  = 6'h0D;
  localparam logic [5:0] OPC_LUI  = 6'h0F;

  localparam logic [5:0] FN_SLL = 6'h00;
  localparam logic [5:0] FN_SRL = 6'h02;
  localparam logic [5:0] FN_SRA = 6'h03;
  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_NOR = 6'h27;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [3:0] {
    K_ADD, K_SUB, K_AND, K_OR, K_NOR, K_SLT,
    K_SHL, K_SHR, K_SHRA, K_PASS_IMM, K_NONE
  } alu_kind_e;

  typedef enum logic [1:0] {
    EXT_OFF, EXT_SIGN, EXT_ZERO, EXT_HIGH
  } ext_mode_e;

  typedef struct packed {
    alu_kind_e kind;
    ext_mode_e ext;
    logic      unknown;
  } alu_ctl_t;

  function automatic logic [XLEN-1:0] f_sum(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
    return a + b;
  endfunction

  function automatic logic [XLEN-1:0] f_diff(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
    return a - b;
  endfunction

  function automatic logic [XLEN-1:0] f_lt_signed(input logic [XLEN-1:0] a, input logic [XLEN-1:0] b);
    return {{(XLEN-1){1'b0}}, ($signed(a) < $signed(b))};
  endfunction
endpackage

// File: rtl/rdec_decode.sv
module rdec_decode
  import rdec_pkg::*;
(
  input  logic [5:0] opc,
  input  logic [5:0] fn,
  output alu_ctl_t   ctl
);
  always_comb begin
    ctl = '{kind: K_NONE, ext: EXT_OFF, unknown: 1'b1};
    unique case (opc)
      OPC_REG: begin
        ctl.ext = EXT_OFF;
        ctl.unknown = 1'b0;
        case (fn)
          FN_ADD:  ctl.kind = K_ADD;
          FN_SUB:  ctl.kind = K_SUB;
          FN_AND:  ctl.kind = K_AND;
          FN_OR:   ctl.kind = K_OR;
          FN_NOR:  ctl.kind = K_NOR;
          FN_SLT:  ctl.kind = K_SLT;
          FN_SLL:  ctl.kind = K_SHL;
          FN_SRL:  ctl.kind = K_SHR;
          FN_SRA:  ctl.kind = K_SHRA;
          default: begin
            ctl.kind = K_NONE;
            ctl.unknown = 1'b1;
          end
        endcase
      end
      OPC_ADDI: ctl = '{kind: K_ADD,      ext: EXT_SIGN, unknown: 1'b0};
      OPC_SLTI: ctl = '{kind: K_SLT,      ext: EXT_SIGN, unknown: 1'b0};
      OPC_ANDI: ctl = '{kind: K_AND,      ext: EXT_ZERO, unknown: 1'b0};
      OPC_ORI:  ctl = '{kind: K_OR,       ext: EXT_ZERO, unknown: 1'b0};
      OPC_LUI:  ctl = '{kind: K_PASS_IMM, ext: EXT_HIGH, unknown: 1'b0};
      default:  ctl = '{kind: K_NONE,     ext: EXT_OFF,  unknown: 1'b1};
    endcase
  end

  always_comb begin
    p_unknown_kind_r10: assert (ctl.unknown == (ctl.kind == K_NONE))
      else $error("decode: unknown flag and kind disagree");
  end
endmodule

// File: rtl/rdec_immext.sv
module rdec_immext
  import rdec_pkg::*;
#(
  parameter int W   = XLEN,
  parameter int IW  = IMM_W
) (
  input  logic [IW-1:0] imm,
  input  ext_mode_e     mode,
  output logic [W-1:0]  wide
);
  localparam int PAD = W - IW;

  always_comb begin
    unique case (mode)
      EXT_SIGN: wide = {{PAD{imm[IW-1]}}, imm};
      EXT_ZERO: wide = {{PAD{1'b0}}, imm};
      EXT_HIGH: wide = {imm, {PAD{1'b0}}};
      default:  wide = '0;
    endcase
  end

  always_comb begin
    p_zext_top_clear_r7: assert (!(mode == EXT_ZERO) || wide[W-1:IW] == '0)
      else $error("immext: zero extension leaked into upper bits");
    p_high_low_clear_r8: assert (!(mode == EXT_HIGH) || wide[PAD-1:0] == '0)
      else $error("immext: upper placement left lower bits set");
  end
endmodule

// File: rtl/rdec_shift.sv
module rdec_shift #(
  parameter int W  = 32,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  din,
  input  logic [SW-1:0] amt,
  input  logic          to_right,
  input  logic          arith,
  output logic [W-1:0]  dout
);
  logic [W-1:0] flip_in;
  logic [W-1:0] flip_out;
  logic [W-1:0] core_in;
  logic         fill;
  logic [W-1:0] stage [0:SW];

  for (genvar i = 0; i < W; i++) begin : g_flip
    assign flip_in[i]  = din[W-1-i];
    assign flip_out[i] = stage[SW][W-1-i];
  end

  assign core_in  = to_right ? din : flip_in;
  assign fill     = to_right & arith & din[W-1];
  assign stage[0] = core_in;

  for (genvar k = 0; k < SW; k++) begin : g_stage
    localparam int D = 2 ** k;
    assign stage[k+1] = amt[k] ? {{D{fill}}, stage[k][W-1:D]} : stage[k];
  end

  assign dout = to_right ? stage[SW] : flip_out;

  always_comb begin
    p_srl_top_zero_r4: assert (!(to_right && !arith && amt != '0) || dout[W-1] == 1'b0)
      else $error("shift: logical right shift did not clear top bit");
    p_sra_keeps_sign_r4: assert (!(to_right && arith) || dout[W-1] == din[W-1])
      else $error("shift: arithmetic right shift lost sign");
    p_sll_low_zero_r4: assert (!(!to_right && amt != '0) || dout[0] == 1'b0)
      else $error("shift: left shift did not clear bit 0");
  end
endmodule

// File: rtl/rdec_alu.sv
module rdec_alu
  import rdec_pkg::*;
#(
  parameter int DATA_W = XLEN,
  parameter int IMM_BITS = IMM_W
) (
  input  logic [5:0]          op_code,
  input  logic [5:0]          fn_code,
  input  logic [4:0]          sh_amt,
  input  logic [DATA_W-1:0]   src_a,
  input  logic [DATA_W-1:0]   src_b,
  input  logic [IMM_BITS-1:0] imm16,
  output logic [DATA_W-1:0]   res,
  output logic                res_zero,
  output logic                bad_op
);
  localparam int SHW = $clog2(DATA_W);

  alu_ctl_t          ctl;
  logic [DATA_W-1:0] imm_wide;
  logic [DATA_W-1:0] opnd_b;
  logic [DATA_W-1:0] shift_out;
  logic              shift_right;
  logic              shift_arith;

  rdec_decode u_dec (
    .opc (op_code),
    .fn  (fn_code),
    .ctl (ctl)
  );

  rdec_immext #(.W(DATA_W), .IW(IMM_BITS)) u_ext (
    .imm  (imm16),
    .mode (ctl.ext),
    .wide (imm_wide)
  );

  assign shift_right = (ctl.kind == K_SHR) || (ctl.kind == K_SHRA);
  assign shift_arith = (ctl.kind == K_SHRA);

  rdec_shift #(.W(DATA_W), .SW(SHW)) u_sh (
    .din      (src_b),
    .amt      (sh_amt[SHW-1:0]),
    .to_right (shift_right),
    .arith    (shift_arith),
    .dout     (shift_out)
  );

  assign opnd_b = (ctl.ext == EXT_OFF) ? src_b : imm_wide;

  always_comb begin
    unique case (ctl.kind)
      K_ADD:      res = f_sum(src_a, opnd_b);
      K_SUB:      res = f_diff(src_a, opnd_b);
      K_AND:      res = src_a & opnd_b;
      K_OR:       res = src_a | opnd_b;
      K_NOR:      res = ~(src_a | opnd_b);
      K_SLT:      res = f_lt_signed(src_a, opnd_b);
      K_SHL,
      K_SHR,
      K_SHRA:     res = shift_out;
      K_PASS_IMM: res = imm_wide;
      default:    res = '0;
    endcase
  end

  assign res_zero = (res == '0);
  assign bad_op   = ctl.unknown;

  always_comb begin
    p_bad_gives_zero_r10: assert (!bad_op || (res == '0 && res_zero))
      else $error("alu: unknown encoding produced a nonzero result");
    p_slt_is_bit_r3: assert (!(ctl.kind == K_SLT) || res[DATA_W-1:1] == '0)
      else $error("alu: compare result wider than one bit");
    p_lui_low_clear_r8: assert (!(op_code == OPC_LUI) || res[DATA_W-IMM_BITS-1:0] == '0)
      else $error("alu: load-upper left lower bits set");
    p_zero_implies_empty_r9: assert (!res_zero || !(|res))
      else $error("alu: zero flag set on nonzero result");
  end
endmodule

// File: tb/test_rdec_alu.sv
module test_rdec_alu;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  op_code = '0;
  logic [5:0]  fn_code = '0;
  logic [4:0]  sh_amt = '0;
  logic [31:0] src_a = '0;
  logic [31:0] src_b = '0;
  logic [15:0] imm16 = '0;
  logic [31:0] res;
  logic        res_zero;
  logic        bad_op;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  rdec_alu i_rdec_alu (
    .op_code (op_code),
    .fn_code (fn_code),
    .sh_amt  (sh_amt),
    .src_a   (src_a),
    .src_b   (src_b),
    .imm16   (imm16),
    .res     (res),
    .res_zero(res_zero),
    .bad_op  (bad_op)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 20000 && !done) begin
      done = 1'b1;
      errors = errors + 1;
      $display("FAIL watchdog expired at cycle %0d", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, got, exp);
    end
  endtask

  task automatic run(input string tag, input logic [5:0] opc, input logic [5:0] fn,
                     input logic [4:0] sh, input logic [31:0] a, input logic [31:0] b,
                     input logic [15:0] im, input logic [31:0] exp_res, input logic exp_bad);
    @(posedge clk);
    #1;
    op_code = opc; fn_code = fn; sh_amt = sh;
    src_a = a; src_b = b; imm16 = im;
    @(negedge clk);
    chk({tag, " result"}, res, exp_res);
    chk({tag, " R9 zero flag"}, {31'b0, res_zero}, {31'b0, (exp_res == 32'h0)});
    chk({tag, " R10 bad_op"}, {31'b0, bad_op}, {31'b0, exp_bad});
  endtask

  task automatic t_reset_state();
    @(negedge clk);
    chk("R4 R9 idle result", res, 32'h0);
    chk("R9 idle zero flag", {31'b0, res_zero}, 32'h1);
    chk("R10 idle bad_op", {31'b0, bad_op}, 32'h0);
  endtask

  task automatic t_add_sub_r1();
    run("R1 add carry into sign", 6'h00, 6'h20, 5'd7, 32'h7FFF_FFFF, 32'h1, 16'h1234, 32'h8000_0000, 1'b0);
    run("R1 add wraps to zero",   6'h00, 6'h20, 5'd0, 32'hFFFF_FFFF, 32'h1, 16'h0,    32'h0,         1'b0);
    run("R1 sub negative",        6'h00, 6'h22, 5'd0, 32'd5,         32'd7, 16'h0,    32'hFFFF_FFFE, 1'b0);
    run("R1 sub equal",           6'h00, 6'h22, 5'd3, 32'd10,        32'd10,16'h0,    32'h0,         1'b0);
  endtask

  task automatic t_logic_r2();
    logic [31:0] a = 32'hF0F0_1234;
    logic [31:0] b = 32'h0FF0_FF00;
    run("R2 and", 6'h00, 6'h24, 5'd0, a, b, 16'hFFFF, a & b,    1'b0);
    run("R2 or",  6'h00, 6'h25, 5'd0, a, b, 16'h0,    a | b,    1'b0);
    run("R2 nor", 6'h00, 6'h27, 5'd0, a, b, 16'h0,    ~(a | b), 1'b0);
  endtask

  task automatic t_slt_r3();
    run("R3 neg below pos",  6'h00, 6'h2A, 5'd0, 32'hFFFF_FFFF, 32'h1,         16'h0, 32'h1, 1'b0);
    run("R3 pos above neg",  6'h00, 6'h2A, 5'd0, 32'h1,         32'hFFFF_FFFF, 16'h0, 32'h0, 1'b0);
    run("R3 equal",          6'h00, 6'h2A, 5'd0, 32'd42,        32'd42,        16'h0, 32'h0, 1'b0);
    run("R3 min below max",  6'h00, 6'h2A, 5'd0, 32'h8000_0000, 32'h7FFF_FFFF, 16'h0, 32'h1, 1'b0);
  endtask

  task automatic t_shift_r4();
    logic [31:0] v = 32'h8000_00F1;
    run("R4 sll 4",  6'h00, 6'h00, 5'd4,  32'hDEAD_BEEF, v, 16'h0, v << 4, 1'b0);
    run("R4 srl 4",  6'h00, 6'h02, 5'd4,  32'hDEAD_BEEF, v, 16'h0, v >> 4, 1'b0);
    run("R4 sra 4",  6'h00, 6'h03, 5'd4,  32'hDEAD_BEEF, v, 16'h0, 32'hF800_000F, 1'b0);
    run("R4 sra 31", 6'h00, 6'h03, 5'd31, 32'h0,         v, 16'h0, 32'hFFFF_FFFF, 1'b0);
    run("R4 srl 31", 6'h00, 6'h02, 5'd31, 32'h0,         v, 16'h0, 32'h1, 1'b0);
    run("R4 sll 31", 6'h00, 6'h00, 5'd31, 32'h0,         v, 16'h0, 32'h8000_0000, 1'b0);
    run("R4 sll 0",  6'h00, 6'h00, 5'd0,  32'h5555_5555, v, 16'h0, v, 1'b0);
    run("R4 sra pos",6'h00, 6'h03, 5'd8,  32'h0, 32'h7000_0000, 16'h0, 32'h0070_0000, 1'b0);
  endtask

  task automatic t_addi_r5();
    run("R5 addi minus one", 6'h08, 6'h3F, 5'd0, 32'd10,    32'hAAAA_AAAA, 16'hFFFF, 32'd9,       1'b0);
    run("R5 addi positive",  6'h08, 6'h00, 5'd0, 32'h100,   32'h1234_5678, 16'h7FFF, 32'h80FF,    1'b0);
    run("R5 addi to zero",   6'h08, 6'h00, 5'd0, 32'h8000,  32'h1,         16'h8000, 32'h0,       1'b0);
  endtask

  task automatic t_slti_r6();
    run("R6 slti 5 < -1",  6'h0A, 6'h00, 5'd0, 32'd5,         32'h0, 16'hFFFF, 32'h0, 1'b0);
    run("R6 slti -2 < -1", 6'h0A, 6'h00, 5'd0, 32'hFFFF_FFFE, 32'h0, 16'hFFFF, 32'h1, 1'b0);
    run("R6 slti 3 < 4",   6'h0A, 6'h00, 5'd0, 32'd3,         32'hFFFF_FFFF, 16'h0004, 32'h1, 1'b0);
  endtask

  task automatic t_logic_imm_r7();
    run("R7 andi zext", 6'h0C, 6'h00, 5'd0, 32'hFFFF_FFFF, 32'h0, 16'h8001, 32'h0000_8001, 1'b0);
    run("R7 ori zext",  6'h0D, 6'h00, 5'd0, 32'h1234_0000, 32'hFFFF_FFFF, 16'h8000, 32'h1234_8000, 1'b0);
  endtask

  task automatic t_lui_r8();
    run("R8 lui place", 6'h0F, 6'h00, 5'd9, 32'h0000_1111, 32'h2222_2222, 16'hABCD, 32'hABCD_0000, 1'b0);
    run("R8 lui zero",  6'h0F, 6'h00, 5'd0, 32'hFFFF_FFFF, 32'h0,         16'h0000, 32'h0,         1'b0);
  endtask

  task automatic t_unknown_r10();
    run("R10 reg fn 0x21", 6'h00, 6'h21, 5'd0, 32'h5, 32'h6, 16'h1, 32'h0, 1'b1);
    run("R10 reg fn 0x01", 6'h00, 6'h01, 5'd4, 32'h5, 32'hF0, 16'h1, 32'h0, 1'b1);
    run("R10 opcode 0x23", 6'h23, 6'h20, 5'd0, 32'h5, 32'h6, 16'h7, 32'h0, 1'b1);
    run("R10 opcode 0x3F", 6'h3F, 6'h00, 5'd0, 32'hFFFF_FFFF, 32'h1, 16'hFFFF, 32'h0, 1'b1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_reset_state();
    t_add_sub_r1();
    t_logic_r2();
    t_slt_r3();
    t_shift_r4();
    t_addi_r5();
    t_slti_r6();
    t_logic_imm_r7();
    t_lui_r8();
    t_unknown_r10();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule